// File: doc/BRIEF.md
# PWM Event-Trigger Interrupt Prescaler

This block produces the interrupt request of one PWM channel. From the time-base it receives the counter value, a count-direction flag, and single-cycle strobes that mark counter-equals-zero and counter-equals-period. It also receives four compare thresholds. A source-select code picks one qualifying event from these inputs. The event can be zero, period, zero-or-period, or an equality between the counter and one of the four thresholds while the counter runs in a chosen direction.

Each qualifying event advances a small prescale counter. When the counter reaches the programmed divide value, the interrupt flag is raised and the counter restarts from zero. The flag stays up until software clears it. Events that arrive while the flag is pending are still counted, but they cannot raise a second request. The thresholds named C and D serve only this trigger path. They do not drive any PWM output.

Top module: `etp_irq_prescaler`

## Requirements
- R1: While `rst` is high, on every clock edge, `irq_flag` and `evt_cnt` return to 0.
- R2: Source codes select time-base strobes. 1 selects `zero_stb`, 2 selects `prd_stb`, and 3 selects either strobe.
- R3: Source codes 4, 5, 6 and 7 select an up-count match against thresholds A, B, C and D in that order. A match means `cnt_val` equals the threshold while `cnt_dir` is 1.
- R4: Source codes 8, 9, 10 and 11 select a down-count match against thresholds A, B, C and D in that order. A match means `cnt_val` equals the threshold while `cnt_dir` is 0.
- R5: Source codes 0 and 12 to 15 select no event. With these codes, `evt_cnt` does not change and `irq_flag` is not raised.
- R6: While `irq_en` is low, the next edge sets `evt_cnt` to 0, and no event raises `irq_flag`.
- R7: While `evt_target` is 0, interrupt generation is off. The next edge sets `evt_cnt` to 0, and `irq_flag` is not raised.
- R8: With generation on, each qualifying event adds 1 to `evt_cnt` at the next edge, and cycles without an event leave it unchanged. On the event that brings the count to `evt_target`, `evt_cnt` becomes 0 and `irq_flag` becomes 1.
- R9: While `irq_flag` is 1, qualifying events keep advancing and wrapping `evt_cnt` in the same way, and `irq_flag` stays 1.
- R10: `irq_flag` stays 1 until a cycle with `flag_clr` high. At the next edge it falls to 0, unless R11 applies.
- R11: When `flag_clr` and a count-completing event fall in the same cycle, the new request wins and `irq_flag` is 1 after the edge.
- R12: If `evt_target` is lowered to a value at or below the current count, the next qualifying event sets `evt_cnt` to 0 and raises `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Time-base counter value |
| cnt_dir | input | 1 | Count direction, 1 = up, 0 = down |
| zero_stb | input | 1 | Counter-equals-zero strobe |
| prd_stb | input | 1 | Counter-equals-period strobe |
| cmp_a | input | CNT_W | Threshold A |
| cmp_b | input | CNT_W | Threshold B |
| cmp_c | input | CNT_W | Threshold C (trigger use only) |
| cmp_d | input | CNT_W | Threshold D (trigger use only) |
| irq_en | input | 1 | Interrupt generation enable |
| src_sel | input | 4 | Event source code (see R2 to R5) |
| evt_target | input | 4 | Events per interrupt, 0 = off |
| flag_clr | input | 1 | Clears the pending flag |
| irq_flag | output | 1 | Pending interrupt request |
| evt_cnt | output | 4 | Current prescale count |

## Verification
The bench builds the block with `CNT_W` set to 6. The counter value and all four thresholds are drawn from the range 0 to 5, so random cycles hit equalities in both directions on every threshold quite often. Divide values cover the whole 4-bit range, including 0 and 15. Long stretches with the flag left pending exercise the wrap behaviour in R9. Clears that land on the completing event exercise R11.

// File: rtl/etp_pkg.sv
package etp_pkg;

    localparam int EVT_W = 4;
    localparam int NCMP  = 4;
    localparam int SRC_W = 4;

    typedef enum logic [SRC_W-1:0] {
        SRC_OFF  = 4'd0,
        SRC_ZERO = 4'd1,
        SRC_PRD  = 4'd2,
        SRC_ZP   = 4'd3,
        SRC_UP0  = 4'd4,
        SRC_DN0  = 4'd8
    } src_e;

    typedef struct packed {
        logic             flag;
        logic [EVT_W-1:0] cnt;
    } etp_state_t;

    function automatic logic src_is_up(input logic [SRC_W-1:0] s);
        return (s >= SRC_UP0) && (s < SRC_UP0 + SRC_W'(NCMP));
    endfunction

    function automatic logic src_is_dn(input logic [SRC_W-1:0] s);
        return (s >= SRC_DN0) && (s < SRC_DN0 + SRC_W'(NCMP));
    endfunction

endpackage

// File: rtl/etp_event_sel.sv
module etp_event_sel
    import etp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CNT_W-1:0]            cnt_val,
    input  logic                        cnt_dir,
    input  logic                        zero_stb,
    input  logic                        prd_stb,
    input  logic [NCMP-1:0][CNT_W-1:0]  cmp_vals,
    input  logic [SRC_W-1:0]            src_sel,
    output logic                        evt
);

    logic [NCMP-1:0] eq;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        assign eq[i] = (cnt_val == cmp_vals[i]);
    end

    always_comb begin
        evt = 1'b0;
        case (src_sel)
            SRC_ZERO: evt = zero_stb;
            SRC_PRD:  evt = prd_stb;
            SRC_ZP:   evt = zero_stb | prd_stb;
            default: begin
                for (int i = 0; i < NCMP; i++) begin
                    if (src_sel == SRC_UP0 + SRC_W'(i)) evt = eq[i] & cnt_dir;
                    if (src_sel == SRC_DN0 + SRC_W'(i)) evt = eq[i] & ~cnt_dir;
                end
            end
        endcase
    end

    // R3: an up-direction source only fires while counting up
    p_up_dir_r3: assert property (@(posedge clk) disable iff (rst)
        (evt && src_is_up(src_sel)) |-> cnt_dir);

    // R4: a down-direction source only fires while counting down
    p_dn_dir_r4: assert property (@(posedge clk) disable iff (rst)
        (evt && src_is_dn(src_sel)) |-> !cnt_dir);

    // R5: unused codes never produce an event
    p_off_src_r5: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_OFF || src_sel >= SRC_DN0 + SRC_W'(NCMP)) |-> !evt);

endmodule

// File: rtl/etp_prescale.sv
module etp_prescale
    import etp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             irq_en,
    input  logic [EVT_W-1:0] target,
    input  logic             clr,
    output logic             flag,
    output logic [EVT_W-1:0] cnt
);

    etp_state_t st, st_nxt;
    logic       gen_on;
    logic [EVT_W:0] inc;

    assign gen_on = irq_en && (target != '0);
    assign inc    = {1'b0, st.cnt} + 1'b1;

    always_comb begin
        st_nxt = st;
        if (clr) st_nxt.flag = 1'b0;
        if (!gen_on) begin
            st_nxt.cnt = '0;
        end else if (evt) begin
            if (inc >= {1'b0, target}) begin
                st_nxt.cnt  = '0;
                st_nxt.flag = 1'b1;
            end else begin
                st_nxt.cnt = inc[EVT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nxt;
    end

    assign flag = st.flag;
    assign cnt  = st.cnt;

    // R6: disabled generation clears the count
    p_dis_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> (cnt == '0));

    // R7: zero divide value never raises the flag
    p_zero_tgt_r7: assert property (@(posedge clk) disable iff (rst)
        (target == '0 && !flag) |=> !flag);

    // R8: count holds when no event arrives
    p_hold_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        (gen_on && !evt) |=> $stable(cnt));

    // R8: the flag rises only together with a count restart
    p_rise_restart_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> (cnt == '0));

    // R10: pending flag persists without a clear
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R10: clear without a completing event drops the flag
    p_flag_clr_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !flag);

endmodule

// File: rtl/etp_irq_prescaler.sv
module etp_irq_prescaler
    import etp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_dir,
    input  logic             zero_stb,
    input  logic             prd_stb,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cmp_c,
    input  logic [CNT_W-1:0] cmp_d,
    input  logic             irq_en,
    input  logic [3:0]       src_sel,
    input  logic [3:0]       evt_target,
    input  logic             flag_clr,
    output logic             irq_flag,
    output logic [3:0]       evt_cnt
);

    logic [NCMP-1:0][CNT_W-1:0] cmp_vals;
    logic                       evt;

    assign cmp_vals = {cmp_d, cmp_c, cmp_b, cmp_a};

    etp_event_sel #(.CNT_W(CNT_W)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .cnt_val  (cnt_val),
        .cnt_dir  (cnt_dir),
        .zero_stb (zero_stb),
        .prd_stb  (prd_stb),
        .cmp_vals (cmp_vals),
        .src_sel  (src_sel),
        .evt      (evt)
    );

    etp_prescale u_pre (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .irq_en (irq_en),
        .target (evt_target),
        .clr    (flag_clr),
        .flag   (irq_flag),
        .cnt    (evt_cnt)
    );

endmodule

// File: tb/sim_etp_irq_prescaler.sv
module sim_etp_irq_prescaler;

    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] cnt_val, cmp_a, cmp_b, cmp_c, cmp_d;
    logic          cnt_dir, zero_stb, prd_stb, irq_en, flag_clr;
    logic [3:0]    src_sel, evt_target;
    logic          irq_flag;
    logic [3:0]    evt_cnt;

    int n_vec  = 0;
    int n_fail = 0;
    int m_cnt;
    bit m_flag;

    always #4ns clk = ~clk;

    etp_irq_prescaler #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_dir(cnt_dir),
        .zero_stb(zero_stb), .prd_stb(prd_stb),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cmp_d(cmp_d),
        .irq_en(irq_en), .src_sel(src_sel), .evt_target(evt_target),
        .flag_clr(flag_clr), .irq_flag(irq_flag), .evt_cnt(evt_cnt)
    );

    function automatic bit ev_fn();
        logic [CW-1:0] c [4];
        c[0] = cmp_a; c[1] = cmp_b; c[2] = cmp_c; c[3] = cmp_d;
        case (src_sel)
            4'd1: return zero_stb;
            4'd2: return prd_stb;
            4'd3: return zero_stb | prd_stb;
            4'd4, 4'd5, 4'd6, 4'd7:
                return cnt_dir && (cnt_val == c[int'(src_sel) - 4]);
            4'd8, 4'd9, 4'd10, 4'd11:
                return !cnt_dir && (cnt_val == c[int'(src_sel) - 8]);
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_edge();
        bit e, nf;
        e  = ev_fn();
        nf = m_flag;
        if (rst) begin
            m_cnt = 0; m_flag = 1'b0;
        end else begin
            if (flag_clr) nf = 1'b0;
            if (!(irq_en && evt_target != 4'd0)) m_cnt = 0;
            else if (e) begin
                if (m_cnt + 1 >= int'(evt_target)) begin m_cnt = 0; nf = 1'b1; end
                else m_cnt = m_cnt + 1;
            end
            m_flag = nf;
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        #1ns;
        n_vec++;
        if (irq_flag !== m_flag || int'(evt_cnt) != m_cnt) begin
            n_fail++;
            $display("FAIL %s: flag=%0b cnt=%0d expected flag=%0b cnt=%0d",
                     tag, irq_flag, evt_cnt, m_flag, m_cnt);
        end
    endtask

    task automatic idle_in();
        zero_stb = 0; prd_stb = 0; flag_clr = 0;
    endtask

    task automatic pulse_zero(input string tag);
        zero_stb = 1; step(tag); zero_stb = 0; step(tag);
    endtask

    initial begin
        #(200000 * 8ns);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1; cnt_val = 0; cnt_dir = 1; cmp_a = 1; cmp_b = 2; cmp_c = 3; cmp_d = 4;
        irq_en = 1; src_sel = 4'd1; evt_target = 4'd3; idle_in();
        m_cnt = 0; m_flag = 0;
        step("R1"); step("R1"); step("R1");
        rst = 0;

        // R2: zero strobe, divide by 3
        repeat (3) pulse_zero("R2");
        src_sel = 4'd2; flag_clr = 1; step("R10"); flag_clr = 0;
        prd_stb = 1; step("R2"); step("R2"); step("R2"); prd_stb = 0; step("R2");
        src_sel = 4'd3; zero_stb = 1; prd_stb = 1; step("R2"); prd_stb = 0; step("R2");
        zero_stb = 0; step("R2");

        // R9: pending flag, count keeps wrapping
        repeat (4) pulse_zero("R9");

        // R10: clear
        flag_clr = 1; step("R10"); flag_clr = 0; step("R10");

        // R3: up match on C only while up
        src_sel = 4'd6; cnt_val = cmp_c; cnt_dir = 1; step("R3"); step("R3");
        cnt_dir = 0; step("R3"); step("R3");
        // R4: down match on B only while down
        src_sel = 4'd9; cnt_val = cmp_b; step("R4"); cnt_dir = 1; step("R4");
        cnt_dir = 0; cnt_val = cmp_d; step("R4");
        // R3: D up
        src_sel = 4'd7; cnt_dir = 1; step("R3");
        // R5: unused codes
        src_sel = 4'd13; zero_stb = 1; prd_stb = 1; step("R5"); step("R5");
        src_sel = 4'd0; step("R5"); zero_stb = 0; prd_stb = 0;

        // R6 / R7
        src_sel = 4'd1; flag_clr = 1; step("R10"); flag_clr = 0;
        zero_stb = 1; step("R8"); irq_en = 0; step("R6"); step("R6"); irq_en = 1;
        evt_target = 4'd0; step("R7"); step("R7"); zero_stb = 0;

        // R11: clear coinciding with the completing event
        evt_target = 4'd2; pulse_zero("R8");
        flag_clr = 1; zero_stb = 1; step("R11"); flag_clr = 0; zero_stb = 0; step("R11");

        // R12: lower divide below current count
        flag_clr = 1; step("R10"); flag_clr = 0;
        evt_target = 4'd8; repeat (4) pulse_zero("R8");
        evt_target = 4'd2; pulse_zero("R12");

        // R8 / R9 / R10 / R11 randomised
        for (int i = 0; i < 4000; i++) begin
            if (i % 40 == 0) begin
                src_sel    = 4'($urandom_range(0, 15));
                evt_target = 4'($urandom_range(0, 15));
            end
            irq_en   = ($urandom_range(0, 19) != 0);
            flag_clr = ($urandom_range(0, 9) == 0);
            zero_stb = ($urandom_range(0, 3) == 0);
            prd_stb  = ($urandom_range(0, 3) == 0);
            cnt_dir  = 1'($urandom_range(0, 1));
            cnt_val  = CW'($urandom_range(0, 5));
            cmp_a    = CW'($urandom_range(0, 5));
            cmp_b    = CW'($urandom_range(0, 5));
            cmp_c    = CW'($urandom_range(0, 5));
            cmp_d    = CW'($urandom_range(0, 5));
            step("R8");
        end

        // R1: reset from an active state
        rst = 1; step("R1"); rst = 0; idle_in(); step("R1");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule